// File: doc/BRIEF.md
# Programmable Input Noise Rejection Filter

This block cleans up one external input pin before it reaches an edge-triggered interrupt detector and a timer event counter. The pin goes through a two-stage synchronizer, then through an optional polarity inversion. A sampler then reads the result at one of three selectable rates, every 1, 16 or 64 enabled cycles. The filtered level moves to a new value only when two consecutive samples both show that value. So a disturbance that covers no more than one sample period is never passed on, and a level held for two sample periods is always passed on.

The filtered level is the timer's count input. A one-clock edge pulse for the interrupt logic is derived from the filtered level alone, never from the raw pin. The edge mode selects whether rising, falling or both transitions raise that pulse, or whether none does. Sampling advances only on clocks where the cycle-rate enable is high, so all rejection times are measured in enabled cycles.

Top module: `pin_noise_filter`

## Requirements
- R1: After reset, `level_out` and `edge_pulse` are both 0.
- R2: With `rate_sel`=00 and `cyc_en` held high, a pin change held steady shows on `level_out` exactly 4 clocks after the first rising clock edge that captures it. A high pulse 1 clock wide is rejected, and one 2 clocks wide is accepted.
- R3: With `rate_sel`=01, a high pulse of up to 16 enabled cycles never changes `level_out`, and a pulse of 32 enabled cycles always does.
- R4: With `rate_sel`=10 or 11, a high pulse of up to 64 enabled cycles never changes `level_out`, and a pulse of 128 enabled cycles always does.
- R5: When `invert_pol`=1, the pin is inverted before filtering, so a steady low pin gives `level_out`=1 and a steady high pin gives `level_out`=0.
- R6: `edge_pulse` is high for exactly one clock, in the same clock that `level_out` changes. It fires only for the transitions chosen by `edge_mode`: 00 rising only, 01 falling only, 10 both, 11 none.
- R7: While `cyc_en` is low, sampling is frozen and `level_out` holds its value whatever the pin does.
- R8: `level_out` changes only right after a sample strobe, and only to a value that the previous sample also held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cyc_en | input | 1 | Cycle-rate enable; sampling counts only these cycles |
| pin_in | input | 1 | Raw asynchronous pin |
| rate_sel | input | 2 | Sample period: 00 = 1, 01 = 16, 10/11 = 64 enabled cycles |
| invert_pol | input | 1 | 1 = invert the pin before filtering |
| edge_mode | input | 2 | 00 rising, 01 falling, 10 both, 11 no edge pulses |
| level_out | output | 1 | Filtered level (timer event input) |
| edge_pulse | output | 1 | One-clock pulse on a selected filtered transition |

## Verification
At the one-cycle rate the filtered level is due exactly four clocks after the pin change is first captured: two synchronizer stages, one sample, one accept. The bench samples on falling edges at the third and fourth clock, and the edge pulse is checked in that same fourth clock and found low in the next. At the slower rates the strobe phase is unknown, so pulses of exactly N and 2N enabled cycles are applied, where N is the sample period. The bench then waits more than four sample periods and counts rises of the level and edge pulses over the whole window. The result therefore does not depend on where the strobe fell.

// File: rtl/pin_nf_pkg.sv
package pin_nf_pkg;

  typedef enum logic [1:0] {
    EDGE_RISE = 2'b00,
    EDGE_FALL = 2'b01,
    EDGE_BOTH = 2'b10,
    EDGE_NONE = 2'b11
  } edge_mode_e;

  // Sample period, in enabled cycles, for a rate selection.
  function automatic int unsigned period_of(input logic [1:0] sel,
                                            input int unsigned mid,
                                            input int unsigned slow);
    case (sel)
      2'b00:   return 1;
      2'b01:   return mid;
      default: return slow;
    endcase
  endfunction

  // Whether a transition to new_lvl should raise an edge pulse.
  function automatic logic edge_wanted(input logic [1:0] mode, input logic new_lvl);
    case (mode)
      EDGE_RISE: return new_lvl;
      EDGE_FALL: return !new_lvl;
      EDGE_BOTH: return 1'b1;
      default:   return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/nf_sync.sv
module nf_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh <= '0;
        else        sh <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh <= '0;
        else        sh <= {sh[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = sh[STAGES-1];
endmodule

// File: rtl/nf_strobe.sv
module nf_strobe
  import pin_nf_pkg::*;
#(
  parameter int DIV_MID  = 16,
  parameter int DIV_SLOW = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cyc_en,
  input  logic [1:0] rate_sel,
  output logic       strobe
);
  localparam int CW = (DIV_SLOW > 1) ? $clog2(DIV_SLOW) : 1;

  logic [CW-1:0] cnt;
  logic [CW-1:0] limit;

  assign limit  = CW'(period_of(rate_sel, DIV_MID, DIV_SLOW) - 1);
  // >= keeps the strobe going when a shorter period is selected mid-count
  assign strobe = cyc_en && (cnt >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (cyc_en) cnt <= strobe ? '0 : cnt + 1'b1;
  end

  AST_CNT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_en |=> (cnt == $past(cnt))); // R7
endmodule

// File: rtl/nf_accept.sv
module nf_accept (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  input  logic cond,
  output logic level,
  output logic take
);
  logic samp_q;
  logic level_q;

  assign take  = strobe && (cond == samp_q) && (cond != level_q);
  assign level = level_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      samp_q  <= 1'b0;
      level_q <= 1'b0;
    end else begin
      if (strobe) samp_q  <= cond;
      if (take)   level_q <= cond;
    end
  end

  AST_CHANGE_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (level_q != $past(level_q)) |-> $past(strobe)); // R8
  AST_PRIOR_SAMPLE_AGREES: assert property (@(posedge clk) disable iff (!rst_n)
    (level_q != $past(level_q)) |-> ($past(samp_q) == level_q)); // R8
endmodule

// File: rtl/nf_edge.sv
module nf_edge
  import pin_nf_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       take,
  input  logic       new_lvl,
  input  logic [1:0] mode,
  output logic       pulse
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse <= 1'b0;
    else        pulse <= take && edge_wanted(mode, new_lvl);
  end

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |=> !pulse); // R6
endmodule

// File: rtl/pin_noise_filter.sv
module pin_noise_filter
  import pin_nf_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DIV_MID     = 16,
  parameter int DIV_SLOW    = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cyc_en,
  input  logic       pin_in,
  input  logic [1:0] rate_sel,
  input  logic       invert_pol,
  input  logic [1:0] edge_mode,
  output logic       level_out,
  output logic       edge_pulse
);
  logic pin_sync;
  logic cond;
  logic strobe;
  logic take;

  nf_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pin_sync)
  );

  assign cond = pin_sync ^ invert_pol;

  nf_strobe #(.DIV_MID(DIV_MID), .DIV_SLOW(DIV_SLOW)) u_strobe (
    .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .rate_sel(rate_sel), .strobe(strobe)
  );

  nf_accept u_accept (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .cond(cond),
    .level(level_out), .take(take)
  );

  nf_edge u_edge (
    .clk(clk), .rst_n(rst_n), .take(take), .new_lvl(cond),
    .mode(edge_mode), .pulse(edge_pulse)
  );

  AST_PULSE_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    edge_pulse |-> (level_out != $past(level_out))); // R6
  AST_RISE_MODE_ONLY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_pulse && ($past(edge_mode) == EDGE_RISE)) |-> level_out); // R6
  AST_FALL_MODE_ONLY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_pulse && ($past(edge_mode) == EDGE_FALL)) |-> !level_out); // R6
  AST_SILENT_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(edge_mode) == EDGE_NONE) |-> !edge_pulse); // R6
  AST_HOLD_WITHOUT_EN: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cyc_en) |-> $stable(level_out)); // R7
endmodule

// File: tb/pin_noise_filter_tb.sv
`timescale 1ns/1ps
module pin_noise_filter_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cyc_en = 1'b1;
  logic       pin_in = 1'b0;
  logic [1:0] rate_sel = 2'b00;
  logic       invert_pol = 1'b0;
  logic [1:0] edge_mode = 2'b10;
  logic       level_out;
  logic       edge_pulse;

  int checks = 0;
  int failures = 0;
  int rise_cnt = 0;
  int edge_cnt = 0;
  logic prev_lvl = 1'b0;

  always #2.5 clk = ~clk;

  pin_noise_filter u_dut (
    .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .pin_in(pin_in),
    .rate_sel(rate_sel), .invert_pol(invert_pol), .edge_mode(edge_mode),
    .level_out(level_out), .edge_pulse(edge_pulse)
  );

  // Observation on falling edges
  always @(negedge clk) begin
    if (rst_n) begin
      if (edge_pulse) edge_cnt++;
      if (level_out && !prev_lvl) rise_cnt++;
      prev_lvl = level_out;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Apply a high pulse of w cycles, then wait long enough for any response.
  task automatic pulse(input int w, output int rises, output int edges);
    int r0, e0;
    r0 = rise_cnt; e0 = edge_cnt;
    pin_in = 1'b1;
    idle(w);
    pin_in = 1'b0;
    idle(300);
    rises = rise_cnt - r0;
    edges = edge_cnt - e0;
  endtask

  // {rate, width, 5'b0, accepted}
  localparam logic [15:0] VEC [10] = '{
    {2'd0, 8'd1,   5'd0, 1'b0},
    {2'd0, 8'd2,   5'd0, 1'b1},
    {2'd1, 8'd15,  5'd0, 1'b0},
    {2'd1, 8'd16,  5'd0, 1'b0},
    {2'd1, 8'd32,  5'd0, 1'b1},
    {2'd2, 8'd64,  5'd0, 1'b0},
    {2'd2, 8'd128, 5'd0, 1'b1},
    {2'd3, 8'd64,  5'd0, 1'b0},
    {2'd3, 8'd128, 5'd0, 1'b1},
    {2'd2, 8'd130, 5'd0, 1'b1}
  };

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    int r, e;
    idle(3);
    // R1: reset state
    chk(level_out == 1'b0, "R1 level", level_out, 0);
    chk(edge_pulse == 1'b0, "R1 edge", edge_pulse, 0);
    rst_n = 1'b1;
    idle(5);

    // R2: exact latency at the one-cycle rate, R6 pulse alignment
    pin_in = 1'b1;
    idle(3);
    chk(level_out == 1'b0, "R2 not yet at 3", level_out, 0);
    idle(1);
    chk(level_out == 1'b1, "R2 level at 4", level_out, 1);
    chk(edge_pulse == 1'b1, "R6 pulse with change", edge_pulse, 1);
    idle(1);
    chk(edge_pulse == 1'b0, "R6 pulse one wide", edge_pulse, 0);
    pin_in = 1'b0;
    idle(10);

    // Table: rejection/acceptance per rate (R2 R3 R4), both edges
    for (int i = 0; i < 10; i++) begin
      rate_sel = VEC[i][15:14];
      idle(2);
      pulse(int'(VEC[i][13:6]), r, e);
      if (VEC[i][15:14] == 2'd0)      chk(r == int'(VEC[i][0]), "R2 rises", r, int'(VEC[i][0]));
      else if (VEC[i][15:14] == 2'd1) chk(r == int'(VEC[i][0]), "R3 rises", r, int'(VEC[i][0]));
      else                            chk(r == int'(VEC[i][0]), "R4 rises", r, int'(VEC[i][0]));
      chk(e == 2 * int'(VEC[i][0]), "R6 both-edge count", e, 2 * int'(VEC[i][0]));
    end

    // R6: edge mode selection
    rate_sel = 2'b00;
    edge_mode = 2'b00; pulse(4, r, e);
    chk(e == 1, "R6 rising only", e, 1);
    edge_mode = 2'b01; pulse(4, r, e);
    chk(e == 1, "R6 falling only", e, 1);
    edge_mode = 2'b11; pulse(4, r, e);
    chk(e == 0 && r == 1, "R6 none mode", e, 0);
    edge_mode = 2'b10;

    // R5: polarity inversion
    invert_pol = 1'b1;
    idle(10);
    chk(level_out == 1'b1, "R5 low pin inverted", level_out, 1);
    pin_in = 1'b1;
    idle(10);
    chk(level_out == 1'b0, "R5 high pin inverted", level_out, 0);
    invert_pol = 1'b0;
    idle(10);
    pin_in = 1'b0;
    idle(10);

    // R7: frozen while cycle enable is low
    cyc_en = 1'b0;
    e = edge_cnt;
    pin_in = 1'b1;
    idle(50);
    chk(level_out == 1'b0, "R7 held level", level_out, 0);
    chk(edge_cnt == e, "R7 no edge", edge_cnt - e, 0);
    cyc_en = 1'b1;
    idle(10);
    chk(level_out == 1'b1, "R7 resumes", level_out, 1);
    pin_in = 1'b0;
    idle(10);
    chk(level_out == 1'b0, "R8 settles low", level_out, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule